// File: doc/BRIEF.md
# Fully Associative Address Translation Cache

This block keeps recently used translations from virtual page numbers to physical page numbers. Each translation carries read, write and execute permission bits. A lookup compares the virtual page number of the incoming address with every stored tag at once. In the same cycle it returns the physical address, together with a verdict on whether the requested kind of access is allowed. The low 12 address bits are the offset within the page. They are not translated and go straight into the physical address.

When no stored tag matches, the block raises a miss. An external page-table walker then fetches the translation and writes it in through the refill port. The access completes on a retry after that write. Refills choose their slot in this order:

1. An entry already holding the same tag.
2. Otherwise the lowest-numbered empty entry.
3. Otherwise the entry at a round-robin pointer, which steps forward on every accepted refill.

A flush input empties the whole structure in one clock.

The block has no sequencing states. Lookup is purely combinational. The only sequential controller is the replacement pointer, which has one transition: step to the next index, wrapping after the last, on each accepted refill.

Top module: `tlb_fa`

## Requirements
- R1: After reset no entry is valid. A lookup with `lk_valid` high gives `lk_miss`=1 and `lk_hit`=`lk_pa_valid`=`lk_fault`=0.
- R2: A lookup whose page number matches a valid entry gives `lk_hit`=1 and `lk_miss`=0 in the same cycle. In that case `lk_paddr` = {stored physical page number, `lk_vaddr[11:0]`}.
- R3: A lookup with no matching valid entry gives `lk_miss`=1, `lk_hit`=0, `lk_pa_valid`=0, `lk_fault`=0 and `lk_paddr`=0.
- R4: `lk_acc` encodes 0 = read (needs R), 1 = write (needs W), 2 = execute (needs X), and 3 = reserved (never allowed). A hit whose entry allows the access gives `lk_pa_valid`=1 and `lk_fault`=0. Otherwise the hit gives `lk_fault`=1 and `lk_pa_valid`=0.
- R5: A refill is written at the clock edge that ends its cycle. A lookup in the refill cycle sees the contents from before the write, and the new entry is visible from the next cycle on.
- R6: A refill whose page number equals the tag of a valid entry overwrites that entry, so a tag never appears twice. Later lookups return the newest page number and permissions.
- R7: When any entry is invalid, a refill with a new tag fills the lowest-numbered invalid entry.
- R8: When all entries are valid, a refill with a new tag replaces the entry at the round-robin pointer. The pointer is 0 after reset, is unchanged by flush, and advances by one, modulo the entry count, on every accepted refill.
- R9: A flush invalidates every entry at one clock edge. A refill in the same cycle is discarded and does not move the pointer.
- R10: With `lk_valid` low, `lk_hit`, `lk_miss`, `lk_pa_valid` and `lk_fault` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all entries at the next edge |
| lk_valid | input | 1 | Lookup request present |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| lk_hit | output | 1 | A valid entry matches the page number |
| lk_miss | output | 1 | No valid entry matches; refill needed |
| lk_pa_valid | output | 1 | Hit and access permitted |
| lk_fault | output | 1 | Hit but access not permitted |
| lk_paddr | output | 32 | Physical address on hit, zero otherwise |
| rf_valid | input | 1 | Refill write request |
| rf_vpn | input | 20 | Page number tag to store |
| rf_ppn | input | 20 | Physical page number to store |
| rf_perm_r | input | 1 | Read permission of the new entry |
| rf_perm_w | input | 1 | Write permission of the new entry |
| rf_perm_x | input | 1 | Execute permission of the new entry |

## Verification
Storage faults surface at the ports at different times.

- **Corrupted tag or stale valid bit:** shows up on the very next lookup of that page, as a hit where a miss is due or the reverse.
- **Wrong stored page number or permission bit:** shows up as a wrong `lk_paddr`, or as a swap between `lk_pa_valid` and `lk_fault`.
- **Misplaced victim or wrong replacement pointer:** stays hidden until the structure is full. It then appears as the wrong page going missing, or a just-refilled page missing, within one refill of the slip.

The bench therefore loads more distinct pages than there are entries and probes them between refills.

// File: rtl/tlb_pkg.sv
`timescale 1ns/1ps
package tlb_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_t;

    typedef struct packed {
        logic r;
        logic w;
        logic x;
    } perm_t;

    // Decide whether a stored permission set admits the requested access.
    function automatic logic perm_allows(input perm_t p, input acc_t a);
        logic ok;
        unique case (a)
            ACC_READ:  ok = p.r;
            ACC_WRITE: ok = p.w;
            ACC_EXEC:  ok = p.x;
            ACC_RSVD:  ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/tlb_entry_array.sv
`timescale 1ns/1ps
module tlb_entry_array
    import tlb_pkg::*;
#(
    parameter int N     = 32,
    parameter int VPN_W = 20,
    parameter int PPN_W = 20,
    localparam int IDX_W = $clog2(N)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        flush,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [VPN_W-1:0]            wr_vpn,
    input  logic [PPN_W-1:0]            wr_ppn,
    input  perm_t                       wr_perm,
    output logic [N-1:0]                valid_o,
    output logic [N-1:0][VPN_W-1:0]     tags_o,
    output logic [N-1:0][PPN_W-1:0]     ppns_o,
    output perm_t [N-1:0]               perms_o
);

    logic [N-1:0] valid_q;

    for (genvar g = 0; g < N; g++) begin : g_entry
        logic sel;
        assign sel = wr_en && !flush && (wr_idx == IDX_W'(g));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                valid_q[g] <= 1'b0;
            end else if (flush) begin
                valid_q[g] <= 1'b0;
            end else if (sel) begin
                valid_q[g] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (sel) begin
                tags_o[g]  <= wr_vpn;
                ppns_o[g]  <= wr_ppn;
                perms_o[g] <= wr_perm;
            end
        end
    end

    assign valid_o = valid_q;

    // R5: an accepted write is present in the chosen slot one edge later
    assert_refill_lands_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush) |=> (valid_q[$past(wr_idx)] && tags_o[$past(wr_idx)] == $past(wr_vpn)));

    // R9: after a flush edge nothing is valid
    assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (valid_q == '0));

endmodule

// File: rtl/tlb_match.sv
`timescale 1ns/1ps
module tlb_match
    import tlb_pkg::*;
#(
    parameter int N     = 32,
    parameter int VPN_W = 20,
    parameter int PPN_W = 20
) (
    input  logic [N-1:0]                valid,
    input  logic [N-1:0][VPN_W-1:0]     tags,
    input  logic [N-1:0][PPN_W-1:0]     ppns,
    input  perm_t [N-1:0]               perms,
    input  logic [VPN_W-1:0]            vpn,
    output logic [N-1:0]                match_vec,
    output logic                        hit_any,
    output logic [PPN_W-1:0]            hit_ppn,
    output perm_t                       hit_perm
);

    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign match_vec[g] = valid[g] && (tags[g] == vpn);
    end

    assign hit_any = |match_vec;

    // AND-OR mux: relies on at most one match being active
    always_comb begin
        hit_ppn  = '0;
        hit_perm = '0;
        for (int i = 0; i < N; i++) begin
            hit_ppn  = hit_ppn  | (ppns[i]  & {PPN_W{match_vec[i]}});
            hit_perm = hit_perm | (perms[i] & {3{match_vec[i]}});
        end
    end

endmodule

// File: rtl/tlb_victim.sv
`timescale 1ns/1ps
module tlb_victim #(
    parameter int N     = 32,
    parameter int VPN_W = 20,
    localparam int IDX_W = $clog2(N)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N-1:0]                valid,
    input  logic [N-1:0][VPN_W-1:0]     tags,
    input  logic [VPN_W-1:0]            rf_vpn,
    input  logic                        advance,
    output logic [IDX_W-1:0]            victim_idx
);

    logic [N-1:0]     same_vec;
    logic             same_hit;
    logic [IDX_W-1:0] same_idx;
    logic             free_any;
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] rr_ptr;

    for (genvar g = 0; g < N; g++) begin : g_same
        assign same_vec[g] = valid[g] && (tags[g] == rf_vpn);
    end

    assign same_hit = |same_vec;

    always_comb begin
        same_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (same_vec[i]) same_idx = IDX_W'(i);
        end
    end

    // Downward scan so the lowest invalid index wins
    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!valid[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    always_comb begin
        if (same_hit)      victim_idx = same_idx;
        else if (free_any) victim_idx = free_idx;
        else               victim_idx = rr_ptr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rr_ptr <= '0;
        end else if (advance) begin
            rr_ptr <= (rr_ptr == IDX_W'(N - 1)) ? '0 : rr_ptr + 1'b1;
        end
    end

    // R7: a new tag with free room never lands on a live entry
    assert_free_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !same_hit && free_any) |-> !valid[victim_idx]);

    // R8: pointer holds still without a refill
    assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(rr_ptr));

endmodule

// File: rtl/tlb_fa.sv
`timescale 1ns/1ps
module tlb_fa
    import tlb_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int OFS_W   = 12,
    localparam int VPN_W  = VA_W - OFS_W,
    localparam int PPN_W  = PA_W - OFS_W,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              lk_valid,
    input  logic [VA_W-1:0]   lk_vaddr,
    input  logic [1:0]        lk_acc,
    output logic              lk_hit,
    output logic              lk_miss,
    output logic              lk_pa_valid,
    output logic              lk_fault,
    output logic [PA_W-1:0]   lk_paddr,
    input  logic              rf_valid,
    input  logic [VPN_W-1:0]  rf_vpn,
    input  logic [PPN_W-1:0]  rf_ppn,
    input  logic              rf_perm_r,
    input  logic              rf_perm_w,
    input  logic              rf_perm_x
);

    logic [ENTRIES-1:0]             valid;
    logic [ENTRIES-1:0][VPN_W-1:0]  tags;
    logic [ENTRIES-1:0][PPN_W-1:0]  ppns;
    perm_t [ENTRIES-1:0]            perms;
    logic [ENTRIES-1:0]             match_vec;
    logic                           hit_any;
    logic [PPN_W-1:0]               hit_ppn;
    perm_t                          hit_perm;
    logic [IDX_W-1:0]               victim_idx;
    logic                           refill_go;
    logic                           allowed;
    perm_t                          rf_perm;

    assign refill_go = rf_valid && !flush;
    assign rf_perm   = '{r: rf_perm_r, w: rf_perm_w, x: rf_perm_x};

    tlb_entry_array #(.N(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (flush),
        .wr_en   (rf_valid),
        .wr_idx  (victim_idx),
        .wr_vpn  (rf_vpn),
        .wr_ppn  (rf_ppn),
        .wr_perm (rf_perm),
        .valid_o (valid),
        .tags_o  (tags),
        .ppns_o  (ppns),
        .perms_o (perms)
    );

    tlb_match #(.N(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W)) u_match (
        .valid     (valid),
        .tags      (tags),
        .ppns      (ppns),
        .perms     (perms),
        .vpn       (lk_vaddr[VA_W-1:OFS_W]),
        .match_vec (match_vec),
        .hit_any   (hit_any),
        .hit_ppn   (hit_ppn),
        .hit_perm  (hit_perm)
    );

    tlb_victim #(.N(ENTRIES), .VPN_W(VPN_W)) u_victim (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid      (valid),
        .tags       (tags),
        .rf_vpn     (rf_vpn),
        .advance    (refill_go),
        .victim_idx (victim_idx)
    );

    always_comb begin
        allowed     = perm_allows(hit_perm, acc_t'(lk_acc));
        lk_hit      = lk_valid && hit_any;
        lk_miss     = lk_valid && !hit_any;
        lk_pa_valid = lk_hit && allowed;
        lk_fault    = lk_hit && !allowed;
        lk_paddr    = lk_hit ? {hit_ppn, lk_vaddr[OFS_W-1:0]} : '0;
    end

    // R6: tags stay unique, so at most one comparator fires
    assert_single_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

    // R9: a lookup right after a flush cannot hit
    assert_flush_no_hit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !lk_hit);

    // R4: a fault only on a hit, and never with a valid address
    assert_fault_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_fault |-> (lk_hit && !lk_pa_valid));

    // R2: page offset passes through on a hit
    assert_offset_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> (lk_paddr[OFS_W-1:0] == lk_vaddr[OFS_W-1:0]));

    // R10: idle lookup port is silent
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |-> !(lk_hit || lk_miss || lk_pa_valid || lk_fault));

endmodule

// File: tb/tb_tlb_fa.sv
`timescale 1ns/1ps
module tb_tlb_fa;

    localparam int N     = 32;
    localparam int VPN_W = 20;
    localparam int PPN_W = 20;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              flush = 1'b0;
    logic              lk_valid = 1'b0;
    logic [31:0]       lk_vaddr = '0;
    logic [1:0]        lk_acc = '0;
    logic              lk_hit, lk_miss, lk_pa_valid, lk_fault;
    logic [31:0]       lk_paddr;
    logic              rf_valid = 1'b0;
    logic [VPN_W-1:0]  rf_vpn = '0;
    logic [PPN_W-1:0]  rf_ppn = '0;
    logic              rf_perm_r = 1'b0, rf_perm_w = 1'b0, rf_perm_x = 1'b0;

    tlb_fa dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_acc(lk_acc),
        .lk_hit(lk_hit), .lk_miss(lk_miss), .lk_pa_valid(lk_pa_valid),
        .lk_fault(lk_fault), .lk_paddr(lk_paddr),
        .rf_valid(rf_valid), .rf_vpn(rf_vpn), .rf_ppn(rf_ppn),
        .rf_perm_r(rf_perm_r), .rf_perm_w(rf_perm_w), .rf_perm_x(rf_perm_x)
    );

    always #2.5 clk = ~clk;

    // Reference model of the requirements
    bit               m_v [N];
    logic [VPN_W-1:0] m_tag [N];
    logic [PPN_W-1:0] m_ppn [N];
    bit               m_r [N], m_w [N], m_x [N];
    int               m_ptr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    function automatic int m_find(input logic [VPN_W-1:0] vpn);
        for (int i = 0; i < N; i++) if (m_v[i] && m_tag[i] == vpn) return i;
        return -1;
    endfunction

    function automatic logic [35:0] m_expect(input logic lv, input logic [31:0] va,
                                             input logic [1:0] acc);
        int  idx;
        bit  ok;
        if (!lv) return '0;
        idx = m_find(va[31:12]);
        if (idx < 0) return {4'b0100, 32'h0};
        case (acc)
            2'd0:    ok = m_r[idx];
            2'd1:    ok = m_w[idx];
            2'd2:    ok = m_x[idx];
            default: ok = 1'b0;
        endcase
        return {1'b1, 1'b0, ok, !ok, m_ppn[idx], va[11:0]};
    endfunction

    task automatic model_edge();
        int idx;
        if (flush) begin
            for (int i = 0; i < N; i++) m_v[i] = 1'b0;
        end else if (rf_valid) begin
            idx = m_find(rf_vpn);
            if (idx < 0) begin
                for (int i = N - 1; i >= 0; i--) if (!m_v[i]) idx = i;
            end
            if (idx < 0) idx = m_ptr;
            m_v[idx] = 1'b1; m_tag[idx] = rf_vpn; m_ppn[idx] = rf_ppn;
            m_r[idx] = rf_perm_r; m_w[idx] = rf_perm_w; m_x[idx] = rf_perm_x;
            m_ptr = (m_ptr + 1) % N;
        end
    endtask

    task automatic check_lookup(input string req);
        logic [35:0] exp, act;
        exp = m_expect(lk_valid, lk_vaddr, lk_acc);
        act = {lk_hit, lk_miss, lk_pa_valid, lk_fault, lk_paddr};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s va=%h acc=%0d actual hit/miss/pav/flt=%b pa=%h expected %b pa=%h",
                     req, lk_vaddr, lk_acc, act[35:32], act[31:0], exp[35:32], exp[31:0]);
        end
    endtask

    // One cycle: drive, check lookup against pre-edge model, advance model.
    task automatic step(input logic lv, input logic [31:0] va, input logic [1:0] acc,
                        input logic rv, input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn,
                        input logic [2:0] rwx, input logic fl, input string req);
        @(negedge clk);
        lk_valid = lv; lk_vaddr = va; lk_acc = acc;
        rf_valid = rv; rf_vpn = vpn; rf_ppn = ppn;
        {rf_perm_r, rf_perm_w, rf_perm_x} = rwx;
        flush = fl;
        #1;
        check_lookup(req);
        @(posedge clk);
        model_edge();
    endtask

    task automatic look(input logic [31:0] va, input logic [1:0] acc, input string req);
        step(1'b1, va, acc, 1'b0, '0, '0, 3'b000, 1'b0, req);
    endtask

    task automatic fill(input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn,
                        input logic [2:0] rwx, input string req);
        step(1'b0, 32'h0, 2'd0, 1'b1, vpn, ppn, rwx, 1'b0, req);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < N; i++) m_v[i] = 1'b0;
        m_ptr = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: empty after reset
        look(32'h0000_5123, 2'd0, "R1");
        look(32'h1234_5FFF, 2'd2, "R1");

        // R5: lookup in the refill cycle sees the old (empty) contents
        step(1'b1, 32'h1234_5ABC, 2'd0, 1'b1, 20'h12345, 20'hABCDE, 3'b100, 1'b0, "R5");
        look(32'h1234_5ABC, 2'd0, "R2");      // read allowed, pa = ABCDE_ABC
        look(32'h1234_5001, 2'd1, "R4");      // write denied
        look(32'h1234_5002, 2'd2, "R4");      // execute denied
        look(32'h1234_5003, 2'd3, "R4");      // reserved never allowed
        look(32'h1234_6000, 2'd0, "R3");      // neighbouring page misses

        // R6: same tag overwrites with new page and permissions
        fill(20'h12345, 20'h11111, 3'b011, "R6");
        look(32'h1234_5777, 2'd0, "R6");      // read now faults
        look(32'h1234_5777, 2'd1, "R6");      // write ok, new ppn
        look(32'h1234_5777, 2'd2, "R6");

        // R10: idle port silent even for a matching address
        step(1'b0, 32'h1234_5777, 2'd1, 1'b0, '0, '0, 3'b000, 1'b0, "R10");

        // R7: 31 new tags fill entries 1..31; pointer ends at 33 mod 32 = 1
        for (int i = 0; i < N - 1; i++) fill(20'h00100 + 20'(i), 20'h80000 + 20'(i), 3'b111, "R7");
        look(32'h0010_0000, 2'd0, "R7");
        look(32'h0011_E000, 2'd1, "R7");
        // R8: full, new tag evicts entry 1 (vpn 0x100)
        fill(20'h00999, 20'h09999, 3'b111, "R8");
        look(32'h0010_0010, 2'd0, "R8");      // evicted: miss
        look(32'h1234_5010, 2'd1, "R8");      // entry 0 survives
        look(32'h0010_1010, 2'd0, "R8");      // entry 2 survives
        look(32'h0099_9444, 2'd2, "R8");
        // next victim is entry 2 (vpn 0x101)
        fill(20'h00AAA, 20'h0AAAA, 3'b100, "R8");
        look(32'h0010_1000, 2'd0, "R8");
        look(32'h0010_2000, 2'd0, "R8");

        // R9: flush with simultaneous refill; refill dropped
        step(1'b1, 32'h0099_9000, 2'd0, 1'b1, 20'h00777, 20'h07777, 3'b111, 1'b1, "R9");
        look(32'h0099_9000, 2'd0, "R9");
        look(32'h0077_7000, 2'd0, "R9");
        look(32'h1234_5000, 2'd1, "R9");

        // Constrained random traffic over more pages than entries
        for (int n = 0; n < 4000; n++) begin
            logic lv, rv, fl;
            logic [VPN_W-1:0] lvpn, rvpn;
            lv   = ($urandom_range(0, 9) != 0);
            rv   = ($urandom_range(0, 2) == 0);
            fl   = ($urandom_range(0, 99) == 0);
            lvpn = 20'h00040 + 20'($urandom_range(0, 47));
            rvpn = 20'h00040 + 20'($urandom_range(0, 47));
            step(lv, {lvpn, 12'($urandom_range(0, 4095))}, 2'($urandom_range(0, 3)),
                 rv, rvpn, 20'($urandom), 3'($urandom_range(0, 7)), fl, "R2/R3/R4/R8 random");
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule